// File: doc/BRIEF.md
# Nine-Bit Serial Command and Data Receiver

This block is the receive side of a three-wire write link between a host microcontroller and a display controller. The host pulls an active-low select line low, then sends a serial clock and a data line. Each frame is nine bits long. The first bit says what the rest carries. The next eight bits are a byte, sent most significant bit first. A byte marked as a command leaves the block on a one-cycle command strobe. A byte marked as pixel data leaves as a write request to display memory. The request carries an address that steps forward by itself after every data byte.

The block runs entirely on a fast system clock. It brings the three serial lines in through two-stage synchronizers and finds serial clock edges by comparing successive samples. Frames follow each other with no gap for as long as select stays low. Raising select at any point discards a partly received frame. Logic outside the block can load a new write position through a load strobe, for example after it decodes a command that sets the address.

Top module: `ser9Receiver`

## Requirements
- R1: After reset, cmdValid and ramWe are 0 and ramAddr is 0.
- R2: A frame whose first bit is 0 gives exactly one cycle of cmdValid, with cmdByte equal to the following eight bits taken MSB first. It gives no ramWe.
- R3: A frame whose first bit is 1 gives exactly one cycle of ramWe, with ramWdata equal to the byte (MSB first) and ramAddr equal to the write position. ramAddr is one higher in the next cycle, and no cmdValid is produced.
- R4: While csN stays low, the rising serial clock edge after the last bit of a frame is the type bit of the next frame. Data and command frames can be freely interleaved.
- R5: While csN is high, serial clock edges produce no output. A frame cut short by csN going high is discarded, and the next frame after csN falls starts with a type bit.
- R6: The write position wraps from 16'hFFFF to 16'h0000 after a data byte.
- R7: A one-cycle addrLoad makes ramAddr equal addrValue in the next cycle. If addrLoad coincides with the increment after a ramWe, the loaded value wins.
- R8: An active-low rstN in the middle of a frame discards the partial frame. If csN is low when rstN is released, the next rising serial clock edge is taken as a type bit.
- R9: cmdValid or ramWe rises on the third system clock edge after the last rising serial clock edge of its frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in |
| addrLoad | input | 1 | One-cycle strobe that loads the write position |
| addrValue | input | 16 | Value loaded by addrLoad |
| cmdValid | output | 1 | One-cycle strobe: a command byte is ready |
| cmdByte | output | 8 | Last command byte received |
| ramWe | output | 1 | One-cycle display memory write request |
| ramWdata | output | 8 | Byte to write |
| ramAddr | output | 16 | Current write position |

## Verification
Each serial rising edge passes two synchronizer flops and one output register, so a result strobe is due on the third system clock edge after the bench drives the last rising serial clock. The bench drives every serial line on a falling system clock edge. It keeps each serial clock level for four system clocks, which gives the receiver time to see every edge. A monitor samples the outputs on falling edges. It logs every strobe with its value and the cycle in which it appeared. The tasks compare the number of strobes, their values and that cycle offset with the expected ones. A load that has to meet the increment is placed three falling edges after the last serial rise, so that it lands on the edge where the increment is due.

// File: rtl/ser9_pkg.sv
package ser9_pkg;
  // strobes from the frame control to the datapath
  typedef struct packed {
    logic clear;   // select inactive: return shifter to idle
    logic shift;   // a qualified serial rising edge this cycle
    logic finish;  // this edge carries the last bit of a frame
  } ser9Strobe_t;
endpackage

// File: rtl/ser9Sync.sv
module ser9Sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= RESET_VAL;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ser9Ctrl.sv
module ser9Ctrl
  import ser9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  output logic        sdiSync,
  output ser9Strobe_t stb
);
  localparam int LAST_BIT = DATA_W;                 // index of final bit in frame
  localparam int CNT_W    = $clog2(LAST_BIT + 1);

  logic csSync, sclkSync, sclkPrev, sclkRise;
  logic [CNT_W-1:0] bitCnt;

  ser9Sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uCsSync (
    .clk(clk), .rstN(rstN), .d(csN), .q(csSync));
  ser9Sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSclkSync (
    .clk(clk), .rstN(rstN), .d(sclk), .q(sclkSync));
  ser9Sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSdiSync (
    .clk(clk), .rstN(rstN), .d(sdi), .q(sdiSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkSync;
  end

  assign sclkRise = sclkSync & ~sclkPrev;

  always_comb begin
    stb.clear  = csSync;
    stb.shift  = ~csSync & sclkRise;
    stb.finish = stb.shift & (bitCnt == CNT_W'(LAST_BIT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bitCnt <= '0;
    else if (stb.clear)    bitCnt <= '0;
    else if (stb.shift)    bitCnt <= stb.finish ? '0 : bitCnt + 1'b1;
  end

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(LAST_BIT));
  // R5
  idle_no_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    csSync |-> !stb.finish);
  // R5
  idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csSync && $past(csSync)) |-> bitCnt == '0);
endmodule

// File: rtl/ser9Data.sv
module ser9Data
  import ser9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ser9Strobe_t       stb,
  input  logic              sdiSync,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrValue,
  output logic              cmdValid,
  output logic [DATA_W-1:0] cmdByte,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  output logic [ADDR_W-1:0] ramAddr
);
  localparam int FLAG_POS = DATA_W - 1;   // type bit sits on top of shifter at frame end

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] fullByte;
  logic              isData;

  assign fullByte = {shReg[DATA_W-2:0], sdiSync};
  assign isData   = shReg[FLAG_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shReg <= '0;
    else if (stb.clear)     shReg <= '0;
    else if (stb.finish)    shReg <= '0;
    else if (stb.shift)     shReg <= fullByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      ramWe    <= 1'b0;
      cmdByte  <= '0;
      ramWdata <= '0;
    end else begin
      cmdValid <= stb.finish & ~isData;
      ramWe    <= stb.finish &  isData;
      if (stb.finish && !isData) cmdByte  <= fullByte;
      if (stb.finish &&  isData) ramWdata <= fullByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ramAddr <= '0;
    else if (addrLoad) ramAddr <= addrValue;
    else if (ramWe)    ramAddr <= ramAddr + 1'b1;
  end

  // R2
  cmd_ram_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && ramWe));
  // R2
  cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  // R3
  ram_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> !ramWe);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && !addrLoad) |=> ramAddr == $past(ramAddr) + 1'b1);
  // R7
  addr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |=> ramAddr == $past(addrValue));
endmodule

// File: rtl/ser9Receiver.sv
module ser9Receiver
  import ser9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrValue,
  output logic              cmdValid,
  output logic [DATA_W-1:0] cmdByte,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  output logic [ADDR_W-1:0] ramAddr
);
  ser9Strobe_t stb;
  logic        sdiSync;

  ser9Ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdiSync(sdiSync), .stb(stb));

  ser9Data #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiSync(sdiSync),
    .addrLoad(addrLoad), .addrValue(addrValue),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .ramWe(ramWe),
    .ramWdata(ramWdata), .ramAddr(ramAddr));
endmodule

// File: tb/ser9Receiver_test.sv
module ser9Receiver_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic addrLoad = 1'b0;
  logic [15:0] addrValue = '0;
  logic cmdValid, ramWe;
  logic [7:0] cmdByte, ramWdata;
  logic [15:0] ramAddr;

  int nChecks = 0, nErrs = 0;
  int cyc = 0;
  int lastRiseCyc = 0;
  int cmdCnt = 0, ramCnt = 0;
  logic [7:0]  cmdLog [0:63];
  int          cmdCyc [0:63];
  logic [7:0]  ramLog [0:63];
  logic [15:0] ramAddrLog [0:63];
  int          ramCyc [0:63];
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  ser9Receiver uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .addrLoad(addrLoad), .addrValue(addrValue),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .ramWe(ramWe),
    .ramWdata(ramWdata), .ramAddr(ramAddr));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmdValid && cmdCnt < 64) begin
      cmdLog[cmdCnt] = cmdByte; cmdCyc[cmdCnt] = cyc; cmdCnt++;
    end
    if (ramWe && ramCnt < 64) begin
      ramLog[ramCnt] = ramWdata; ramAddrLog[ramCnt] = ramAddr;
      ramCyc[ramCnt] = cyc; ramCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input bit doLoad, input logic [15:0] loadVal);
    sdi = b;
    waitClk(4);
    sclk = 1'b1; lastRiseCyc = cyc;
    if (doLoad) begin
      waitClk(3);
      addrLoad = 1'b1; addrValue = loadVal;
      waitClk(1);
      addrLoad = 1'b0;
    end else waitClk(4);
    sclk = 1'b0;
  endtask

  task automatic sendFrame(input logic flag, input logic [7:0] b,
                           input bit doLoad = 0, input logic [15:0] loadVal = '0);
    sendBit(flag, 0, '0);
    for (int i = 7; i >= 0; i--) sendBit(b[i], (i == 0) && doLoad, loadVal);
    waitClk(2);
  endtask

  task automatic selectOn();  csN = 1'b0; waitClk(4); endtask
  task automatic selectOff(); waitClk(4); csN = 1'b1; waitClk(4); endtask

  task automatic testReset();
    check(cmdValid == 0, "R1 cmdValid", cmdValid, 0);
    check(ramWe == 0, "R1 ramWe", ramWe, 0);
    check(ramAddr == 0, "R1 ramAddr", ramAddr, 0);
  endtask

  task automatic testCommand();
    int c0 = cmdCnt, r0 = ramCnt;
    selectOn(); sendFrame(1'b0, 8'hA5); selectOff();
    check(cmdCnt == c0 + 1, "R2 cmd count", cmdCnt - c0, 1);
    check(cmdLog[c0] == 8'hA5, "R2 cmd byte", cmdLog[c0], 8'hA5);
    check(ramCnt == r0, "R2 no ram write", ramCnt - r0, 0);
    check(cmdCyc[c0] - lastRiseCyc == 3, "R9 latency", cmdCyc[c0] - lastRiseCyc, 3);
  endtask

  task automatic testBurst();
    int c0 = cmdCnt, r0 = ramCnt;
    logic [15:0] a0 = ramAddr;
    selectOn();
    sendFrame(1'b1, 8'h11);
    check(ramCyc[r0] - lastRiseCyc == 3, "R9 data latency", ramCyc[r0] - lastRiseCyc, 3);
    sendFrame(1'b0, 8'h3C);
    sendFrame(1'b1, 8'h22);
    selectOff();
    check(ramCnt == r0 + 2, "R4 ram count", ramCnt - r0, 2);
    check(cmdCnt == c0 + 1, "R4 cmd count", cmdCnt - c0, 1);
    check(ramLog[r0] == 8'h11, "R3 data0", ramLog[r0], 8'h11);
    check(ramLog[r0+1] == 8'h22, "R4 data1", ramLog[r0+1], 8'h22);
    check(cmdLog[c0] == 8'h3C, "R4 mid cmd", cmdLog[c0], 8'h3C);
    check(ramAddrLog[r0] == a0, "R3 addr0", ramAddrLog[r0], a0);
    check(ramAddrLog[r0+1] == a0 + 1, "R3 addr1", ramAddrLog[r0+1], a0 + 1);
    check(ramAddr == a0 + 2, "R3 addr after", ramAddr, a0 + 2);
  endtask

  task automatic testIdleAndAbort();
    int c0 = cmdCnt, r0 = ramCnt;
    for (int i = 0; i < 12; i++) begin
      sdi = i[0]; waitClk(4); sclk = 1'b1; waitClk(4); sclk = 1'b0;
    end
    waitClk(6);
    check(cmdCnt == c0 && ramCnt == r0, "R5 idle edges", cmdCnt + ramCnt - c0 - r0, 0);
    selectOn();
    for (int i = 0; i < 4; i++) sendBit(1'b1, 0, '0);
    selectOff();
    check(ramCnt == r0 && cmdCnt == c0, "R5 partial discarded", cmdCnt + ramCnt - c0 - r0, 0);
    selectOn(); sendFrame(1'b0, 8'h5A); selectOff();
    check(cmdCnt == c0 + 1 && cmdLog[c0] == 8'h5A, "R5 fresh frame", cmdLog[c0], 8'h5A);
    check(ramCnt == r0, "R5 no ram", ramCnt - r0, 0);
  endtask

  task automatic testLoadWrap();
    int r0 = ramCnt;
    addrLoad = 1'b1; addrValue = 16'hFFFF; waitClk(1); addrLoad = 1'b0; waitClk(1);
    check(ramAddr == 16'hFFFF, "R7 load", ramAddr, 16'hFFFF);
    selectOn(); sendFrame(1'b1, 8'h77); selectOff();
    check(ramAddrLog[r0] == 16'hFFFF, "R6 write at top", ramAddrLog[r0], 16'hFFFF);
    check(ramAddr == 16'h0000, "R6 wrap", ramAddr, 0);
    selectOn(); sendFrame(1'b1, 8'h88, 1, 16'h1234); selectOff();
    check(ramLog[r0+1] == 8'h88, "R7 data", ramLog[r0+1], 8'h88);
    check(ramAddr == 16'h1234, "R7 load beats step", ramAddr, 16'h1234);
  endtask

  task automatic testResetMid();
    int c0, r0;
    selectOn();
    for (int i = 0; i < 5; i++) sendBit(1'b1, 0, '0);
    rstN = 1'b0; waitClk(2); rstN = 1'b1; waitClk(4);
    c0 = cmdCnt; r0 = ramCnt;
    check(ramAddr == 0, "R8 addr cleared", ramAddr, 0);
    sendFrame(1'b0, 8'hC3); selectOff();
    check(cmdCnt == c0 + 1 && cmdLog[c0] == 8'hC3, "R8 clean frame", cmdLog[c0], 8'hC3);
    check(ramCnt == r0, "R8 no ram", ramCnt - r0, 0);
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    testReset();
    testCommand();
    testBurst();
    testIdleAndAbort();
    testLoadWrap();
    testResetMid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nErrs++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end
endmodule